// File: doc/BRIEF.md
# Host Bus Front End for a Display Controller

This block sits between a microprocessor and the rest of a display controller. It accepts commands and pixel data over one of three host bus styles. Two strap inputs pick the style. The first is a parallel bus with separate active-low read and write strobes. The second is a parallel bus with an active-high enable and a read/write direction line. The third is a write-only two-wire serial link carried on the two lowest data lines. Each accepted host transfer becomes one of three events for the core: an instruction write, a display-data write, or a display-data read request.

All host pins are asynchronous to the controller clock. They pass through a shared synchronizer, and the strobe edges are detected in the clock domain. A write appears as a single-cycle pulse, together with the captured word and a command/data flag. A read raises a single-cycle request. While the host reads, the block drives the bus from the core's read-data input, and a per-line output enable tells the pad ring which lines to drive. The bus can carry 8 or 16 bits per transfer. In 16-bit operation lines 15..8 carry the upper byte.

Top module: `mpu_host_port`

## Requirements
- R1: While `host_csn` is high, no write pulse and no read request is produced and `bus_oe` stays all zero, whatever the strobes do.
- R2: `wr_is_cmd` equals the `host_rs` level of the transfer: 1 (instruction) when high, 0 (display data) when low.
- R3: Strobe mode (`strap_par`=1, `strap_m68`=0): `bus_oe` is non-zero exactly while chip select and `host_rd_e` are both low, and `bus_out` equals `rd_data`. One `rd_req` pulse is issued per falling edge of `host_rd_e`.
- R4: Strobe mode: `host_wr_rw` is an active-low write strobe. The bus value present at its rising edge is emitted as the written word.
- R5: Enable mode (`strap_par`=1, `strap_m68`=1): a write is taken on the falling edge of `host_rd_e` (enable) while `host_wr_rw` is low (0 = write).
- R6: Enable mode: `bus_oe` is non-zero while enable is high and `host_wr_rw` is high (1 = read). One `rd_req` pulse is issued per rising edge of enable with `host_wr_rw` high.
- R7: Serial mode (`strap_par`=0): `bus_in[0]` is the serial clock and `bus_in[1]` the serial data. Bits are taken on the clock's rising edge, MSB first. After 8 bits the word {8'h00, byte} is emitted.
- R8: Serial mode: `bus_oe` stays all zero, so lines 15..5 are never driven. `host_rd_e`, `host_wr_rw` and `bus_in[15:2]` have no effect.
- R9: In serial mode a high `host_csn` discards any partially received bits, and the next byte starts from its MSB.
- R10: With `wide_en`=1 the word is `bus_in[15:0]` and a read drives `bus_oe`=16'hFFFF. With `wide_en`=0 the word is {8'h00, `bus_in[7:0]`} and a read drives `bus_oe`=16'h00FF.
- R11: `wr_pulse` lasts one cycle. It, `rd_req` and `bus_oe` change 3 clock edges after the host pin changes (2 synchronizer stages plus the output register).
- R12: During and right after reset `wr_pulse`, `rd_req` and `bus_oe` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_par | input | 1 | 1 = parallel bus, 0 = serial bus |
| strap_m68 | input | 1 | Parallel style: 1 = enable + direction, 0 = read/write strobes |
| wide_en | input | 1 | 1 = 16-bit transfers, 0 = 8-bit transfers |
| host_csn | input | 1 | Chip select, active low |
| host_rs | input | 1 | 1 = instruction, 0 = display data |
| host_rd_e | input | 1 | Read strobe (active low) or enable (active high) |
| host_wr_rw | input | 1 | Write strobe (active low) or direction (1 = read) |
| bus_in | input | 16 | Host data bus as seen at the pads |
| bus_out | output | 16 | Data driven toward the host |
| bus_oe | output | 16 | Per-line output enable for the pads |
| wr_pulse | output | 1 | One-cycle write event |
| wr_is_cmd | output | 1 | Write is an instruction |
| wr_word | output | 16 | Captured write word |
| rd_req | output | 1 | One-cycle display-read request |
| rd_data | input | 16 | Read data from the core |

## Verification
On every cycle, the embedded properties check the following. Events never follow a high chip select. A serial strap never coincides with driven lines or read requests. Write pulses never repeat in adjacent cycles. The output-enable pattern matches the transfer width. The serial bit counter is cleared whenever chip select is high. The bench scenarios show the rest: the captured values under each bus style, MSB-first bit order, the exact three-edge latency, and that ignored pins really have no effect. They also show that an abandoned partial serial byte leaves no trace in the next byte.

// File: rtl/mhp_pkg.sv
package mhp_pkg;

    localparam int HOST_W     = 16;   // host data bus width
    localparam int LANE_W     = 8;    // narrow transfer width
    localparam int SCL_BIT    = 0;    // serial clock line
    localparam int SDA_BIT    = 1;    // serial data line
    localparam int SER_HIZ_LO = 5;    // lowest line forced undriven in serial mode

    typedef enum logic [1:0] {
        HM_STROBE = 2'd0,
        HM_ENABLE = 2'd1,
        HM_SERIAL = 2'd2
    } host_mode_e;

    typedef struct packed {
        logic csn;
        logic rs;
        logic rd_e;
        logic wr_rw;
    } ctl_t;

    typedef struct packed {
        logic              is_cmd;
        logic [HOST_W-1:0] word;
    } xfer_t;

    localparam ctl_t CTL_IDLE = '{csn: 1'b1, rs: 1'b0, rd_e: 1'b1, wr_rw: 1'b1};

    function automatic host_mode_e decode_mode(input logic par, input logic m68);
        if (!par)
            return HM_SERIAL;
        return m68 ? HM_ENABLE : HM_STROBE;
    endfunction

    function automatic logic [HOST_W-1:0] lane_mask(input logic wide);
        return wide ? {HOST_W{1'b1}}
                    : {{(HOST_W-LANE_W){1'b0}}, {LANE_W{1'b1}}};
    endfunction

    function automatic logic [HOST_W-1:0] fit_word(input logic wide,
                                                   input logic [HOST_W-1:0] raw);
        return raw & lane_mask(wide);
    endfunction

endpackage

// File: rtl/mhp_sync.sv
module mhp_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++)
                stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/mhp_par_decode.sv
module mhp_par_decode
    import mhp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  host_mode_e        mode,
    input  logic              wide,
    input  ctl_t              ctl,
    input  logic [HOST_W-1:0] bus,
    output logic              wr_evt,
    output xfer_t             wr_xfer,
    output logic              rd_evt,
    output logic [HOST_W-1:0] oe_next
);

    logic prev_rd_e;
    logic prev_wr_rw;
    logic active;
    logic drive;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_rd_e  <= CTL_IDLE.rd_e;
            prev_wr_rw <= CTL_IDLE.wr_rw;
        end else begin
            prev_rd_e  <= ctl.rd_e;
            prev_wr_rw <= ctl.wr_rw;
        end
    end

    assign active = (mode != HM_SERIAL) && !ctl.csn;

    always_comb begin
        wr_evt = 1'b0;
        rd_evt = 1'b0;
        drive  = 1'b0;
        if (active) begin
            case (mode)
                HM_STROBE: begin
                    // write strobe released: capture
                    wr_evt = ctl.wr_rw && !prev_wr_rw;
                    // read strobe asserted: request data
                    rd_evt = !ctl.rd_e && prev_rd_e;
                    drive  = !ctl.rd_e;
                end
                HM_ENABLE: begin
                    // enable falls during a write cycle
                    wr_evt = !ctl.rd_e && prev_rd_e && !ctl.wr_rw;
                    // enable rises during a read cycle
                    rd_evt = ctl.rd_e && !prev_rd_e && ctl.wr_rw;
                    drive  = ctl.rd_e && ctl.wr_rw;
                end
                default: begin
                    wr_evt = 1'b0;
                    rd_evt = 1'b0;
                    drive  = 1'b0;
                end
            endcase
        end
    end

    assign oe_next = drive ? lane_mask(wide) : '0;

    always_comb begin
        wr_xfer.is_cmd = ctl.rs;
        wr_xfer.word   = fit_word(wide, bus);
    end

    AST_ENABLE_WRITE_DIR: assert property (@(posedge clk) disable iff (rst)
        (mode == HM_ENABLE && wr_evt) |-> ($past(ctl.rd_e) && !ctl.wr_rw)); // R5

endmodule

// File: rtl/mhp_ser_shift.sv
module mhp_ser_shift
    import mhp_pkg::*;
#(
    parameter int BITS = LANE_W
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  csn,
    input  logic  rs,
    input  logic  scl,
    input  logic  sda,
    output logic  done,
    output xfer_t xfer
);

    localparam int              CW   = $clog2(BITS);
    localparam logic [CW-1:0]   LAST = CW'(BITS - 1);

    logic              prev_scl;
    logic [CW-1:0]     cnt;
    logic [BITS-2:0]   sh;
    logic              rise;
    logic [BITS-1:0]   full;

    assign rise = en && !csn && scl && !prev_scl;
    assign full = {sh, sda};

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_scl <= 1'b0;
            cnt      <= '0;
            sh       <= '0;
        end else begin
            prev_scl <= scl;
            if (!en || csn) begin
                cnt <= '0;
            end else if (rise) begin
                sh  <= full[BITS-2:0];
                cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            end
        end
    end

    assign done = rise && (cnt == LAST);

    always_comb begin
        xfer.is_cmd = rs;
        xfer.word   = HOST_W'(full);
    end

    AST_SER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(csn) |-> (cnt == '0)); // R9

    AST_SER_DONE_EDGE: assert property (@(posedge clk) disable iff (rst)
        done |-> (scl && !csn && en)); // R7

endmodule

// File: rtl/mpu_host_port.sv
module mpu_host_port
    import mhp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SER_BITS    = LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_par,
    input  logic              strap_m68,
    input  logic              wide_en,
    input  logic              host_csn,
    input  logic              host_rs,
    input  logic              host_rd_e,
    input  logic              host_wr_rw,
    input  logic [HOST_W-1:0] bus_in,
    output logic [HOST_W-1:0] bus_out,
    output logic [HOST_W-1:0] bus_oe,
    output logic              wr_pulse,
    output logic              wr_is_cmd,
    output logic [HOST_W-1:0] wr_word,
    output logic              rd_req,
    input  logic [HOST_W-1:0] rd_data
);

    localparam int CTL_W = $bits(ctl_t);

    ctl_t              ctl_raw;
    ctl_t              ctl_s;
    logic [HOST_W-1:0] bus_s;
    host_mode_e        mode;

    logic              par_wr;
    xfer_t             par_xfer;
    logic              par_rd;
    logic [HOST_W-1:0] par_oe;
    logic              ser_wr;
    xfer_t             ser_xfer;

    always_comb begin
        ctl_raw.csn   = host_csn;
        ctl_raw.rs    = host_rs;
        ctl_raw.rd_e  = host_rd_e;
        ctl_raw.wr_rw = host_wr_rw;
    end

    mhp_sync #(
        .W       (CTL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (CTL_IDLE)
    ) u_ctl_sync (
        .clk (clk),
        .rst (rst),
        .d   (ctl_raw),
        .q   (ctl_s)
    );

    mhp_sync #(
        .W       (HOST_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('0)
    ) u_bus_sync (
        .clk (clk),
        .rst (rst),
        .d   (bus_in),
        .q   (bus_s)
    );

    assign mode = decode_mode(strap_par, strap_m68);

    mhp_par_decode u_par (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .wide    (wide_en),
        .ctl     (ctl_s),
        .bus     (bus_s),
        .wr_evt  (par_wr),
        .wr_xfer (par_xfer),
        .rd_evt  (par_rd),
        .oe_next (par_oe)
    );

    mhp_ser_shift #(
        .BITS (SER_BITS)
    ) u_ser (
        .clk  (clk),
        .rst  (rst),
        .en   (mode == HM_SERIAL),
        .csn  (ctl_s.csn),
        .rs   (ctl_s.rs),
        .scl  (bus_s[SCL_BIT]),
        .sda  (bus_s[SDA_BIT]),
        .done (ser_wr),
        .xfer (ser_xfer)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_pulse  <= 1'b0;
            wr_is_cmd <= 1'b0;
            wr_word   <= '0;
            rd_req    <= 1'b0;
            bus_oe    <= '0;
        end else begin
            wr_pulse <= par_wr || ser_wr;
            rd_req   <= par_rd;
            bus_oe   <= par_oe;
            if (par_wr) begin
                wr_is_cmd <= par_xfer.is_cmd;
                wr_word   <= par_xfer.word;
            end else if (ser_wr) begin
                wr_is_cmd <= ser_xfer.is_cmd;
                wr_word   <= ser_xfer.word;
            end
        end
    end

    assign bus_out = rd_data;

    AST_CS_GATES_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |-> $past(!ctl_s.csn)); // R1

    AST_CS_GATES_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_req || bus_oe != '0) |-> $past(!ctl_s.csn)); // R1

    AST_SERIAL_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        $past(!strap_par) |-> (bus_oe[HOST_W-1:SER_HIZ_LO] == '0 && bus_oe == '0)); // R8

    AST_SERIAL_NO_READ: assert property (@(posedge clk) disable iff (rst)
        $past(!strap_par) |-> !rd_req); // R8

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |=> !wr_pulse); // R11

    AST_OE_LANES: assert property (@(posedge clk) disable iff (rst)
        (bus_oe != '0) |-> (bus_oe == lane_mask($past(wide_en)))); // R10

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
        !(par_wr && ser_wr)); // R8

endmodule

// File: tb/mpu_host_port_tb.sv
`timescale 1ns/1ps
module mpu_host_port_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap_par = 1'b1;
    logic        strap_m68 = 1'b0;
    logic        wide_en = 1'b1;
    logic        host_csn = 1'b1;
    logic        host_rs = 1'b0;
    logic        host_rd_e = 1'b1;
    logic        host_wr_rw = 1'b1;
    logic [15:0] bus_in = '0;
    logic [15:0] bus_out;
    logic [15:0] bus_oe;
    logic        wr_pulse;
    logic        wr_is_cmd;
    logic [15:0] wr_word;
    logic        rd_req;
    logic [15:0] rd_data = '0;

    int n_chk = 0;
    int n_err = 0;
    int pulse_cnt = 0;
    int rdreq_cnt = 0;
    logic [15:0] last_word = '0;
    logic        last_cmd = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    mpu_host_port u_dut (
        .clk        (clk),
        .rst        (rst),
        .strap_par  (strap_par),
        .strap_m68  (strap_m68),
        .wide_en    (wide_en),
        .host_csn   (host_csn),
        .host_rs    (host_rs),
        .host_rd_e  (host_rd_e),
        .host_wr_rw (host_wr_rw),
        .bus_in     (bus_in),
        .bus_out    (bus_out),
        .bus_oe     (bus_oe),
        .wr_pulse   (wr_pulse),
        .wr_is_cmd  (wr_is_cmd),
        .wr_word    (wr_word),
        .rd_req     (rd_req),
        .rd_data    (rd_data)
    );

    always @(negedge clk) begin
        if (wr_pulse === 1'b1) begin
            pulse_cnt++;
            last_word = wr_word;
            last_cmd  = wr_is_cmd;
        end
        if (rd_req === 1'b1)
            rdreq_cnt++;
    end

    typedef struct packed {
        logic [1:0]  md;    // 0 strobe, 1 enable, 2 serial
        logic        w16;
        logic        rs;
        logic [15:0] bus;   // serial: byte in [7:0]
        logic [15:0] exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 1'b1, 1'b1, 16'hA5C3, 16'hA5C3},  // R4 wide
        '{2'd0, 1'b0, 1'b0, 16'h7E19, 16'h0019},  // R10 narrow
        '{2'd1, 1'b1, 1'b0, 16'h1234, 16'h1234},  // R5
        '{2'd1, 1'b0, 1'b1, 16'hFF80, 16'h0080},  // R5 narrow
        '{2'd2, 1'b1, 1'b1, 16'h00B6, 16'h00B6},  // R7
        '{2'd2, 1'b0, 1'b0, 16'h0001, 16'h0001},  // R7
        '{2'd0, 1'b1, 1'b0, 16'h0000, 16'h0000},  // R4 zero
        '{2'd2, 1'b1, 1'b0, 16'h0080, 16'h0080}   // R7 msb only
    };

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic [1:0] md, input logic w16);
        host_csn   = 1'b1;
        host_rd_e  = (md == 2'd1) ? 1'b0 : 1'b1;
        host_wr_rw = 1'b1;
        bus_in     = '0;
        strap_par  = (md != 2'd2);
        strap_m68  = (md == 2'd1);
        wide_en    = w16;
        tick(8);
    endtask

    task automatic wr_strobe(input logic rs, input logic [15:0] d);
        host_csn = 1'b0; host_rs = rs; bus_in = d;
        tick(3);
        host_wr_rw = 1'b0;
        tick(3);
        host_wr_rw = 1'b1;
        tick(6);
        host_csn = 1'b1;
        tick(4);
    endtask

    task automatic wr_enable(input logic rs, input logic [15:0] d);
        host_csn = 1'b0; host_rs = rs; host_wr_rw = 1'b0; bus_in = d;
        tick(3);
        host_rd_e = 1'b1;
        tick(3);
        host_rd_e = 1'b0;
        tick(6);
        host_wr_rw = 1'b1; host_csn = 1'b1;
        tick(4);
    endtask

    // upper lines carry junk to show they are ignored (R8)
    task automatic ser_bits(input int n, input logic [7:0] val);
        for (int b = 7; b > 7 - n; b--) begin
            bus_in = {14'h2AAA, val[b], 1'b0};
            tick(3);
            bus_in[0] = 1'b1;
            tick(3);
        end
        bus_in[0] = 1'b0;
        tick(6);
    endtask

    task automatic wr_serial(input logic rs, input logic [7:0] d);
        host_csn = 1'b0; host_rs = rs;
        tick(3);
        ser_bits(8, d);
        host_csn = 1'b1;
        tick(4);
    endtask

    initial begin
        #1600000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int base;
        int rbase;
        int hits;
        int hit_at;
        string tag;

        // reset state, R12
        tick(5);
        check("R12", "wr_pulse in reset", 32'(wr_pulse), 32'h0);
        check("R12", "rd_req in reset", 32'(rd_req), 32'h0);
        check("R12", "bus_oe in reset", 32'(bus_oe), 32'h0);
        rst = 1'b0;
        tick(4);
        check("R12", "bus_oe after reset", 32'(bus_oe), 32'h0);
        check("R12", "no pulse after reset", 32'(pulse_cnt), 32'h0);

        // vector table: one write per entry
        for (int i = 0; i < 8; i++) begin
            set_mode(VECS[i].md, VECS[i].w16);
            base = pulse_cnt;
            case (VECS[i].md)
                2'd0: begin tag = "R4"; wr_strobe(VECS[i].rs, VECS[i].bus); end
                2'd1: begin tag = "R5"; wr_enable(VECS[i].rs, VECS[i].bus); end
                default: begin tag = "R7"; wr_serial(VECS[i].rs, VECS[i].bus[7:0]); end
            endcase
            check(tag, $sformatf("vec%0d pulse count", i), 32'(pulse_cnt - base), 32'd1);
            check(tag, $sformatf("vec%0d word (R10 lanes)", i), 32'(last_word), 32'(VECS[i].exp));
            check("R2", $sformatf("vec%0d cmd flag", i), 32'(last_cmd), 32'(VECS[i].rs));
        end

        // R11: exact latency and single-cycle pulse
        set_mode(2'd0, 1'b1);
        host_csn = 1'b0; host_rs = 1'b1; bus_in = 16'hBEEF;
        tick(3);
        host_wr_rw = 1'b0;
        tick(3);
        host_wr_rw = 1'b1;
        hits = 0; hit_at = 0;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (wr_pulse === 1'b1) begin hits++; hit_at = k; end
        end
        check("R11", "write pulse cycles", 32'(hits), 32'd1);
        check("R11", "write pulse latency", 32'(hit_at), 32'd3);
        host_csn = 1'b1;
        tick(4);

        // R1: chip select high blocks strobe mode
        base = pulse_cnt; rbase = rdreq_cnt;
        host_rd_e = 1'b0;
        tick(4);
        check("R1", "oe with csn high", 32'(bus_oe), 32'h0);
        host_rd_e = 1'b1; host_wr_rw = 1'b0;
        tick(4);
        host_wr_rw = 1'b1;
        tick(6);
        check("R1", "pulses with csn high", 32'(pulse_cnt - base), 32'd0);
        check("R1", "reads with csn high", 32'(rdreq_cnt - rbase), 32'd0);

        // R1: chip select high blocks enable mode
        set_mode(2'd1, 1'b1);
        base = pulse_cnt; rbase = rdreq_cnt;
        host_rd_e = 1'b1;
        tick(4);
        check("R1", "enable-mode oe with csn high", 32'(bus_oe), 32'h0);
        host_rd_e = 1'b0; tick(3);
        host_wr_rw = 1'b0; host_rd_e = 1'b1; tick(3);
        host_rd_e = 1'b0; tick(6);
        host_wr_rw = 1'b1;
        check("R1", "enable-mode events with csn high",
              32'(pulse_cnt - base + rdreq_cnt - rbase), 32'd0);

        // R3: strobe-mode read, wide then narrow
        set_mode(2'd0, 1'b1);
        rbase = rdreq_cnt;
        rd_data = 16'h5A5A;
        host_csn = 1'b0;
        tick(3);
        host_rd_e = 1'b0;
        tick(2);
        check("R11", "oe not yet driven", 32'(bus_oe), 32'h0);
        tick(1);
        check("R3", "oe wide read", 32'(bus_oe), 32'hFFFF);
        check("R3", "bus_out", 32'(bus_out), 32'h5A5A);
        tick(4);
        host_rd_e = 1'b1;
        tick(3);
        check("R3", "oe released", 32'(bus_oe), 32'h0);
        check("R3", "one read request", 32'(rdreq_cnt - rbase), 32'd1);
        wide_en = 1'b0;
        tick(2);
        host_rd_e = 1'b0;
        tick(4);
        check("R10", "oe narrow read", 32'(bus_oe), 32'h00FF);
        host_rd_e = 1'b1; host_csn = 1'b1;
        tick(4);

        // R6: enable-mode read, then write cycle does not drive
        set_mode(2'd1, 1'b1);
        rbase = rdreq_cnt; base = pulse_cnt;
        host_csn = 1'b0;
        tick(3);
        host_rd_e = 1'b1;
        tick(3);
        check("R6", "oe during read", 32'(bus_oe), 32'hFFFF);
        tick(3);
        host_rd_e = 1'b0;
        tick(5);
        check("R6", "oe after enable low", 32'(bus_oe), 32'h0);
        check("R6", "one read request", 32'(rdreq_cnt - rbase), 32'd1);
        check("R6", "read cycle not a write", 32'(pulse_cnt - base), 32'd0);
        host_wr_rw = 1'b0;
        tick(3);
        host_rd_e = 1'b1;
        tick(4);
        check("R6", "no drive in write cycle", 32'(bus_oe), 32'h0);
        host_rd_e = 1'b0;
        tick(6);
        check("R5", "write on enable fall", 32'(pulse_cnt - base), 32'd1);
        check("R6", "no read request in write cycle", 32'(rdreq_cnt - rbase), 32'd1);
        host_wr_rw = 1'b1; host_csn = 1'b1;
        tick(4);

        // R8: serial mode ignores the strobes
        set_mode(2'd2, 1'b1);
        base = pulse_cnt; rbase = rdreq_cnt;
        host_csn = 1'b0;
        bus_in = 16'hFFFC;
        for (int k = 0; k < 4; k++) begin
            host_rd_e  = k[0];
            host_wr_rw = k[1];
            tick(4);
            check("R8", "oe in serial mode", 32'(bus_oe), 32'h0);
        end
        host_rd_e = 1'b1; host_wr_rw = 1'b1;
        tick(4);
        check("R8", "events from strobes", 32'(pulse_cnt - base + rdreq_cnt - rbase), 32'd0);
        host_csn = 1'b1; bus_in = '0;
        tick(4);

        // R9: partial serial byte discarded by chip select
        set_mode(2'd2, 1'b0);
        base = pulse_cnt;
        host_csn = 1'b0; host_rs = 1'b0;
        tick(3);
        ser_bits(3, 8'hE0);
        host_csn = 1'b1;
        tick(4);
        check("R9", "no pulse for partial byte", 32'(pulse_cnt - base), 32'd0);
        wr_serial(1'b1, 8'h3C);
        check("R9", "one pulse for next byte", 32'(pulse_cnt - base), 32'd1);
        check("R9", "byte starts fresh", 32'(last_word), 32'h003C);
        check("R2", "serial cmd flag", 32'(last_cmd), 32'h1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule